// File: doc/BRIEF.md
# Tagged Register Hazard Tracker

This block sits at an in-order issue point and decides whether the instruction on offer may leave. It does not model the pipeline stages behind it. Every accepted instruction that writes a register takes a small producer tag from a ring of four. A per-register table remembers whether a result is still owed and which tag will deliver it.

An instruction that reads an owed register is held. It stays held until the writeback port reports the owed tag. There is no forwarding, so the earliest cycle a consumer can leave is the cycle in which its producer's tag is on the writeback port. A writer is also held when the next tag in the ring still belongs to an unfinished instruction. This limits the number of writers in flight to the number of tags.

The issue side presents up to three source register numbers, each with its own enable, plus a destination number with a write enable. The block answers with a stall flag and shows the tag that a writer accepted in this cycle receives.

Top module: `reg_tag_hazard`

## Requirements
- R1: After reset no register is owed, every tag is free and the next tag is 0. A valid instruction with any sources and destination is accepted (`iss_stall` low), and `iss_tag` reads 0.
- R2: Tags are handed out in ring order 0,1,2,3,0. `iss_tag` shows the tag for the current writer. It advances by one only in a cycle where a valid writer (`iss_dst_we`=1) is accepted.
- R3: A valid instruction stalls if any enabled source names a register whose producer has not yet written back.
- R4: A writeback carrying the owed tag releases a waiting consumer in the same cycle (`iss_stall` low in the writeback cycle).
- R5: Once the tag owed for a register has been written back, that register no longer causes a stall.
- R6: When a younger writer takes a register that is already owed, the register's entry moves to the younger tag. Writeback of the older tag leaves the register owed. Only writeback of the younger tag frees it.
- R7: A writer stalls while the next ring tag is still outstanding (four writers in flight). A tag written back in the current cycle counts as free. A non-writer with no owed sources still issues while all tags are in use.
- R8: A source whose enable bit in `iss_src_vld` is 0 is ignored, whatever register number it carries.
- R9: `iss_stall` is high only when `iss_valid` is high. A stalled instruction claims no tag and changes no table entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | An instruction is offered for issue |
| iss_src_vld | input | 3 | Per-source enable; bit i qualifies source i |
| iss_src | input | 3x6 | Source register numbers, source i in bits [6i+5:6i] |
| iss_dst_we | input | 1 | The offered instruction writes a register |
| iss_dst | input | 6 | Destination register number |
| iss_stall | output | 1 | Offered instruction must wait this cycle |
| iss_tag | output | 2 | Tag given to the writer accepted this cycle |
| wb_valid | input | 1 | A result is being written back |
| wb_tag | input | 2 | Tag of the result being written back |

## Verification
The checker assumes that writeback only reports tags that are actually outstanding, at most once per issued writer. Under that assumption the count of writers in flight never exceeds the number of tags, and the ring pointer advances only on accepted writers. The stimulus keeps within this by issuing writebacks only for tags it has seen accepted and not yet retired. The bench models the owed set and the ring by hand for each step. The sequence fills all four tags and overlaps two writers of the same register. It also lines up writebacks with waiting consumers and stalled writers in the same cycle.

// File: rtl/rth_pkg.sv
package rth_pkg;
   localparam int DEF_NUM_REGS = 64;
   localparam int DEF_TAG_W    = 2;
   localparam int DEF_NUM_SRC  = 3;

   function automatic bit is_pow2(input int v);
      return (v > 1) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/rth_tag_alloc.sv
module rth_tag_alloc #(
   parameter int TAG_W     = 2,
   parameter bit WB_BYPASS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             wb_valid,
   input  logic [TAG_W-1:0] wb_tag,
   output logic [TAG_W-1:0] next_tag,
   output logic             next_busy
);
   localparam int NUM_TAGS = 1 << TAG_W;

   logic [NUM_TAGS-1:0] busy_q;
   logic [TAG_W-1:0]    ptr_q;
   logic                retiring;

   generate
      if (WB_BYPASS) begin : g_byp
         assign retiring = wb_valid && (wb_tag == ptr_q);
      end else begin : g_nobyp
         assign retiring = 1'b0;
      end
   endgenerate

   assign next_tag  = ptr_q;
   assign next_busy = busy_q[ptr_q] && !retiring;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= '0;
         ptr_q  <= '0;
      end else begin
         for (int t = 0; t < NUM_TAGS; t++) begin
            if (take && (ptr_q == TAG_W'(t)))
               busy_q[t] <= 1'b1;
            else if (wb_valid && (wb_tag == TAG_W'(t)))
               busy_q[t] <= 1'b0;
         end
         if (take)
            ptr_q <= ptr_q + TAG_W'(1);
      end
   end
endmodule

// File: rtl/rth_pend_table.sv
module rth_pend_table #(
   parameter int NUM_REGS = 64,
   parameter int TAG_W    = 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             alloc_en,
   input  logic [$clog2(NUM_REGS)-1:0]      alloc_reg,
   input  logic [TAG_W-1:0]                 alloc_tag,
   input  logic                             wb_valid,
   input  logic [TAG_W-1:0]                 wb_tag,
   output logic [NUM_REGS-1:0]              pend,
   output logic [NUM_REGS-1:0][TAG_W-1:0]   ptag
);
   localparam int REG_W = $clog2(NUM_REGS);

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_ent
      logic             pend_q;
      logic [TAG_W-1:0] tag_q;
      logic             set_r;
      logic             clr_r;

      assign set_r = alloc_en && (alloc_reg == REG_W'(r));
      assign clr_r = wb_valid && pend_q && (tag_q == wb_tag);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_q <= 1'b0;
            tag_q  <= '0;
         end else if (set_r) begin
            pend_q <= 1'b1;
            tag_q  <= alloc_tag;
         end else if (clr_r) begin
            pend_q <= 1'b0;
         end
      end

      assign pend[r] = pend_q;
      assign ptag[r] = tag_q;
   end
endmodule

// File: rtl/rth_src_match.sv
module rth_src_match #(
   parameter int NUM_REGS  = 64,
   parameter int TAG_W     = 2,
   parameter int NUM_SRC   = 3,
   parameter bit WB_BYPASS = 1'b1
) (
   input  logic [NUM_SRC-1:0]                        src_vld,
   input  logic [NUM_SRC-1:0][$clog2(NUM_REGS)-1:0]  src,
   input  logic [NUM_REGS-1:0]                       pend,
   input  logic [NUM_REGS-1:0][TAG_W-1:0]            ptag,
   input  logic                                      wb_valid,
   input  logic [TAG_W-1:0]                          wb_tag,
   output logic                                      hazard
);
   logic [NUM_SRC-1:0] hit;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic             owed;
      logic [TAG_W-1:0] want;
      logic             rel;

      assign owed = pend[src[i]];
      assign want = ptag[src[i]];

      if (WB_BYPASS) begin : g_byp
         assign rel = wb_valid && (want == wb_tag);
      end else begin : g_nobyp
         assign rel = 1'b0;
      end

      assign hit[i] = src_vld[i] && owed && !rel;
   end

   assign hazard = |hit;
endmodule

// File: rtl/reg_tag_hazard.sv
module reg_tag_hazard #(
   parameter int NUM_REGS  = rth_pkg::DEF_NUM_REGS,
   parameter int TAG_W     = rth_pkg::DEF_TAG_W,
   parameter int NUM_SRC   = rth_pkg::DEF_NUM_SRC,
   parameter bit WB_BYPASS = 1'b1
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic                                      iss_valid,
   input  logic [NUM_SRC-1:0]                        iss_src_vld,
   input  logic [NUM_SRC-1:0][$clog2(NUM_REGS)-1:0]  iss_src,
   input  logic                                      iss_dst_we,
   input  logic [$clog2(NUM_REGS)-1:0]               iss_dst,
   output logic                                      iss_stall,
   output logic [TAG_W-1:0]                          iss_tag,
   input  logic                                      wb_valid,
   input  logic [TAG_W-1:0]                          wb_tag
);
   if (!rth_pkg::is_pow2(NUM_REGS)) begin : g_bad_regs
      $error("NUM_REGS must be a power of two above 1");
   end
   if (TAG_W < 1 || TAG_W > 4) begin : g_bad_tag
      $error("TAG_W must be between 1 and 4");
   end
   if (NUM_SRC < 1) begin : g_bad_src
      $error("NUM_SRC must be at least 1");
   end

   logic                           src_hazard;
   logic                           tag_full;
   logic                           accept_wr;
   logic [TAG_W-1:0]               next_tag;
   logic [NUM_REGS-1:0]            pend;
   logic [NUM_REGS-1:0][TAG_W-1:0] ptag;

   rth_src_match #(
      .NUM_REGS (NUM_REGS),
      .TAG_W    (TAG_W),
      .NUM_SRC  (NUM_SRC),
      .WB_BYPASS(WB_BYPASS)
   ) u_match (
      .src_vld (iss_src_vld),
      .src     (iss_src),
      .pend    (pend),
      .ptag    (ptag),
      .wb_valid(wb_valid),
      .wb_tag  (wb_tag),
      .hazard  (src_hazard)
   );

   logic next_busy;

   rth_tag_alloc #(
      .TAG_W    (TAG_W),
      .WB_BYPASS(WB_BYPASS)
   ) u_alloc (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (accept_wr),
      .wb_valid (wb_valid),
      .wb_tag   (wb_tag),
      .next_tag (next_tag),
      .next_busy(next_busy)
   );

   assign tag_full  = iss_dst_we && next_busy;
   assign iss_stall = iss_valid && (src_hazard || tag_full);
   assign accept_wr = iss_valid && !iss_stall && iss_dst_we;
   assign iss_tag   = next_tag;

   rth_pend_table #(
      .NUM_REGS(NUM_REGS),
      .TAG_W   (TAG_W)
   ) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .alloc_en (accept_wr),
      .alloc_reg(iss_dst),
      .alloc_tag(next_tag),
      .wb_valid (wb_valid),
      .wb_tag   (wb_tag),
      .pend     (pend),
      .ptag     (ptag)
   );
endmodule

// File: rtl/rth_chk.sv
module rth_chk #(
   parameter int NUM_SRC = 3,
   parameter int TAG_W   = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               iss_valid,
   input logic [NUM_SRC-1:0] iss_src_vld,
   input logic               iss_dst_we,
   input logic               iss_stall,
   input logic [TAG_W-1:0]   iss_tag,
   input logic               wb_valid
);
   localparam int NUM_TAGS = 1 << TAG_W;

   logic             acc_wr;
   logic [TAG_W:0]   inflight_q;

   assign acc_wr = iss_valid && !iss_stall && iss_dst_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         inflight_q <= '0;
      else
         inflight_q <= inflight_q + (TAG_W+1)'(acc_wr) - (TAG_W+1)'(wb_valid);
   end

   AST_TAG_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      acc_wr |=> (iss_tag == TAG_W'($past(iss_tag) + 1'b1)))
      else $error("tag did not advance"); // R2

   AST_TAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_wr |=> $stable(iss_tag))
      else $error("tag moved without writer"); // R2

   AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      inflight_q <= (TAG_W+1)'(NUM_TAGS))
      else $error("too many writers in flight"); // R7

   AST_STALL_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      iss_stall |-> iss_valid)
      else $error("stall without valid"); // R9

   AST_FREE_NONWRITER: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && !iss_dst_we && iss_src_vld == '0) |-> !iss_stall)
      else $error("independent non-writer stalled"); // R8
endmodule

bind reg_tag_hazard rth_chk #(
   .NUM_SRC(NUM_SRC),
   .TAG_W  (TAG_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .iss_valid  (iss_valid),
   .iss_src_vld(iss_src_vld),
   .iss_dst_we (iss_dst_we),
   .iss_stall  (iss_stall),
   .iss_tag    (iss_tag),
   .wb_valid   (wb_valid)
);

// File: tb/reg_tag_hazard_tb_top.sv
`timescale 1ns/1ps
module reg_tag_hazard_tb_top;
   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           iss_valid = 1'b0;
   logic [2:0]     iss_src_vld = '0;
   logic [2:0][5:0] iss_src = '0;
   logic           iss_dst_we = 1'b0;
   logic [5:0]     iss_dst = '0;
   logic           iss_stall;
   logic [1:0]     iss_tag;
   logic           wb_valid = 1'b0;
   logic [1:0]     wb_tag = '0;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   typedef struct {
      bit    stall;
      int    tag;
      string req;
   } exp_t;
   exp_t sb_q[$];

   always #2 clk = ~clk;

   reg_tag_hazard dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .iss_valid  (iss_valid),
      .iss_src_vld(iss_src_vld),
      .iss_src    (iss_src),
      .iss_dst_we (iss_dst_we),
      .iss_dst    (iss_dst),
      .iss_stall  (iss_stall),
      .iss_tag    (iss_tag),
      .wb_valid   (wb_valid),
      .wb_tag     (wb_tag)
   );

   task automatic step(input bit v, input bit [2:0] sv, input int s0, input int s1,
                       input int s2, input bit we, input int dst, input bit wbv,
                       input int wbt, input bit e_stall, input int e_tag, input string req);
      exp_t e;
      @(negedge clk);
      iss_valid   = v;
      iss_src_vld = sv;
      iss_src[0]  = 6'(s0);
      iss_src[1]  = 6'(s1);
      iss_src[2]  = 6'(s2);
      iss_dst_we  = we;
      iss_dst     = 6'(dst);
      wb_valid    = wbv;
      wb_tag      = 2'(wbt);
      e.stall = e_stall;
      e.tag   = e_tag;
      e.req   = req;
      sb_q.push_back(e);
   endtask

   initial begin : monitor
      forever begin
         @(negedge clk);
         #1;
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if (iss_stall !== e.stall || (e.tag >= 0 && int'(iss_tag) != e.tag)) begin
               n_fail++;
               $display("FAIL %s: stall=%0b tag=%0d expected stall=%0b tag=%0d",
                        e.req, iss_stall, iss_tag, e.stall, e.tag);
            end
         end
      end
   end

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: idle after reset, ring starts at 0
      step(0, 3'b000, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 reset idle");
      // R1/R2: first writer to r5 accepted with tag 0
      step(1, 3'b000, 0, 0, 0, 1, 5, 0, 0, 0, 0, "R1 first writer");
      // R3: reader of r5 waits
      step(1, 3'b001, 5, 0, 0, 0, 0, 0, 0, 1, -1, "R3 owed source");
      // R4: released in writeback cycle of tag 0
      step(1, 3'b001, 5, 0, 0, 0, 0, 1, 0, 0, -1, "R4 same-cycle release");
      // R5: r5 no longer owed
      step(1, 3'b001, 5, 0, 0, 0, 0, 0, 0, 0, 1, "R5 cleared after writeback");
      // R2: writers to r7 get tags 1 then 2
      step(1, 3'b000, 0, 0, 0, 1, 7, 0, 0, 0, 1, "R2 tag 1");
      step(1, 3'b000, 0, 0, 0, 1, 7, 0, 0, 0, 2, "R2 tag 2 younger writer");
      // R6: older tag 1 retiring does not free r7
      step(1, 3'b010, 0, 7, 0, 0, 0, 1, 1, 1, -1, "R6 older writeback");
      step(1, 3'b100, 0, 0, 7, 0, 0, 0, 0, 1, -1, "R6 still owed");
      // R8: disabled sources naming r7 ignored
      step(1, 3'b000, 7, 7, 7, 0, 0, 0, 0, 0, -1, "R8 disabled sources");
      // R2/R7: fill the ring
      step(1, 3'b000, 0, 0, 0, 1, 9, 0, 0, 0, 3, "R2 tag 3");
      step(1, 3'b000, 0, 0, 0, 1, 10, 0, 0, 0, 0, "R2 wrap to 0");
      step(1, 3'b000, 0, 0, 0, 1, 11, 0, 0, 0, 1, "R2 tag 1 again");
      step(1, 3'b000, 0, 0, 0, 1, 12, 0, 0, 1, 2, "R7 ring full");
      step(1, 3'b000, 0, 0, 0, 0, 0, 0, 0, 0, -1, "R7 non-writer passes");
      step(1, 3'b000, 0, 0, 0, 1, 12, 1, 2, 0, 2, "R7 tag freed same cycle");
      // R6: tag 2 retired, r7 free
      step(1, 3'b001, 7, 0, 0, 0, 0, 0, 0, 0, 3, "R6 younger writeback frees");
      // R9: stalled writer claims nothing
      step(1, 3'b001, 12, 0, 0, 1, 13, 0, 0, 1, 3, "R9 stalled writer");
      step(1, 3'b001, 12, 0, 0, 1, 13, 1, 3, 1, 3, "R9 stalled with tag retiring");
      step(1, 3'b000, 0, 0, 0, 1, 13, 0, 0, 0, 3, "R9 tag not consumed");
      step(0, 3'b001, 12, 0, 0, 1, 14, 0, 0, 0, 0, "R9 no stall without valid");
      step(0, 3'b000, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 idle ring hold");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule